// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Infrared Pulse Encoding

This block sends one asynchronous character at a time on a single serial output. A byte presented on a valid/ready input is framed with a low start bit and a high stop bit, with seven or eight data bits between them, least significant bit first. Bit timing is built from a tick source that software selects. The source is either a single-cycle tick from an on-chip timer or the rising edges of an external clock pin, which are synchronized into the system clock domain. A prescaler counts 8 or 16 of these ticks per bit period.

The output is either a plain NRZ level that idles high, or an infrared-style waveform. In the infrared waveform a zero bit is a short pulse at the start of the bit period, a one bit holds the idle level, and software picks the polarity. Configuration is written through a one-cycle write strobe. A write that arrives while a character is in flight has no effect. The two clock-synchronized mode codes are accepted into the configuration, but no transmission starts while either is set.

Top module: `irda_async_tx`

## Requirements
- R1: After reset, tx_out is high, busy is low and in_ready is high. The reset configuration is internal tick source, 8-bit asynchronous mode, 16 ticks per bit, infrared encoding off and polarity 0.
- R2: The mode field cfg_mode uses 2'b11 for 8-bit asynchronous, 2'b10 for 7-bit asynchronous, 2'b01 for clocked slave and 2'b00 for clocked master. While either clocked code is set, in_ready stays low, busy stays low and tx_out holds its idle level, with or without infrared encoding.
- R3: A frame is one start bit (0), then the data bits with the LSB first, then one stop bit (1). 8-bit mode sends in_data[7:0]. 7-bit mode sends in_data[6:0] and ignores in_data[7].
- R4: Each bit lasts exactly 16 selected ticks when cfg_div8 is 0, and 8 ticks when cfg_div8 is 1. The first bit begins in the cycle after acceptance.
- R5: With cfg_clk_ext at 0, ticks come from tmr_tick. With cfg_clk_ext at 1, ticks come from rising edges of ext_clk after a two-stage synchronizer, and tmr_tick is ignored.
- R6: With cfg_irda_en at 1, a zero bit drives the active level for the first 3 ticks of its period and the idle level for the rest. A one bit holds the idle level for its whole period.
- R7: With infrared encoding on, cfg_invert 0 gives idle high and low pulses, and cfg_invert 1 gives idle low and high pulses. With encoding off, tx_out is plain NRZ, idles high and ignores cfg_invert.
- R8: in_ready is high only when busy is low and an asynchronous mode is set. A byte is accepted on a clock edge where in_valid and in_ready are both high. busy rises in the next cycle and falls after the last tick of the stop bit.
- R9: A cfg_we pulse while busy is high leaves the configuration unchanged. A pulse while busy is low takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_tick | input | 1 | Single-cycle tick from the internal timer |
| ext_clk | input | 1 | External serial clock pin, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_clk_ext | input | 1 | Tick source: 1 external pin, 0 internal timer |
| cfg_mode | input | 2 | Transfer mode code |
| cfg_div8 | input | 1 | Ticks per bit: 1 gives 8, 0 gives 16 |
| cfg_irda_en | input | 1 | Enable infrared pulse encoding |
| cfg_invert | input | 1 | Infrared output polarity |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte can be accepted |
| busy | output | 1 | Frame in progress |
| tx_out | output | 1 | Serial output |

## Verification
The assertions assume that in_valid and the configuration inputs change only between clock edges. They also assume that tmr_tick is a single-cycle pulse and that the configuration is held stable by the block's own write gating. The stimulus meets these assumptions by driving every input on the falling clock edge, holding tmr_tick high for exactly one cycle per tick, and running ext_clk with a period of several system cycles so that every rising edge reaches the synchronizer. Configuration writes are issued only between frames, except in the test that writes during a frame on purpose to show the write is refused.

// File: rtl/irda_tx_pkg.sv
package irda_tx_pkg;

    localparam int DATA_W      = 8;
    localparam int FRAME_W     = DATA_W + 2;
    localparam int MAX_DIV     = 16;
    localparam int PH_W        = $clog2(MAX_DIV);
    localparam int IDX_W       = $clog2(FRAME_W);
    localparam int PULSE_TICKS = 3;

    typedef enum logic [1:0] {
        MODE_CLK_MASTER = 2'b00,
        MODE_CLK_SLAVE  = 2'b01,
        MODE_ASYNC7     = 2'b10,
        MODE_ASYNC8     = 2'b11
    } tx_mode_e;

    typedef struct packed {
        logic     clk_ext;
        tx_mode_e mode;
        logic     div8;
        logic     irda_en;
        logic     invert;
    } tx_cfg_t;

    localparam tx_cfg_t CFG_RESET = '{
        clk_ext: 1'b0, mode: MODE_ASYNC8, div8: 1'b0, irda_en: 1'b0, invert: 1'b0
    };

    function automatic logic mode_is_async(tx_mode_e m);
        return (m == MODE_ASYNC7) || (m == MODE_ASYNC8);
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(tx_mode_e m, logic [DATA_W-1:0] d);
        if (m == MODE_ASYNC7)
            return {2'b11, d[DATA_W-2:0], 1'b0};
        return {1'b1, d, 1'b0};
    endfunction

    function automatic logic [IDX_W-1:0] frame_last(tx_mode_e m);
        if (m == MODE_ASYNC7)
            return IDX_W'(FRAME_W - 2);
        return IDX_W'(FRAME_W - 1);
    endfunction

    function automatic logic [PH_W-1:0] period_last(logic div8);
        if (div8)
            return PH_W'(MAX_DIV / 2 - 1);
        return PH_W'(MAX_DIV - 1);
    endfunction

endpackage

// File: rtl/irda_tx_clksrc.sv
module irda_tx_clksrc #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic use_ext,
    input  logic tmr_tick,
    input  logic ext_clk,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    sync_q[g] <= 1'b0;
                else if (g == 0)
                    sync_q[g] <= ext_clk;
                else
                    sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= sync_q[SYNC_STAGES-1];
    end

    logic ext_rise;
    assign ext_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign tick     = use_ext ? ext_rise : tmr_tick;

endmodule

// File: rtl/irda_tx_framer.sv
module irda_tx_framer
    import irda_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [IDX_W-1:0]   last_idx,
    input  logic [PH_W-1:0]    period_m1,
    output logic               busy,
    output logic               cur_bit,
    output logic [PH_W-1:0]    phase
);
    logic [FRAME_W-1:0] shift_q;
    logic [IDX_W-1:0]   idx_q;
    logic [PH_W-1:0]    ph_q;
    logic               busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            ph_q    <= '0;
            idx_q   <= '0;
            shift_q <= '1;
        end else if (start) begin
            busy_q  <= 1'b1;
            ph_q    <= '0;
            idx_q   <= '0;
            shift_q <= frame_in;
        end else if (busy_q && tick) begin
            if (ph_q == period_m1) begin
                ph_q <= '0;
                if (idx_q == last_idx) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q   <= idx_q + 1'b1;
                    shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
                end
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign cur_bit = shift_q[0];
    assign phase   = ph_q;

endmodule

// File: rtl/irda_tx_encoder.sv
module irda_tx_encoder
    import irda_tx_pkg::*;
#(
    parameter int PULSE_LEN = PULSE_TICKS
) (
    input  logic            busy,
    input  logic            cur_bit,
    input  logic [PH_W-1:0] phase,
    input  logic            irda_en,
    input  logic            invert,
    output logic            tx
);
    logic nrz;
    logic idle_lvl;
    logic pulse_on;

    always_comb begin
        nrz      = busy ? cur_bit : 1'b1;
        idle_lvl = ~invert;
        pulse_on = busy && !cur_bit && (phase < PH_W'(PULSE_LEN));
        if (irda_en)
            tx = pulse_on ? ~idle_lvl : idle_lvl;
        else
            tx = nrz;
    end

endmodule

// File: rtl/irda_async_tx.sv
module irda_async_tx
    import irda_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_LEN   = PULSE_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_tick,
    input  logic              ext_clk,
    input  logic              cfg_we,
    input  logic              cfg_clk_ext,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_div8,
    input  logic              cfg_irda_en,
    input  logic              cfg_invert,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              tx_out
);
    tx_cfg_t cfg_q;
    logic    tick;
    logic    start;
    logic    cur_bit;
    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (cfg_we && !busy)
            cfg_q <= '{clk_ext: cfg_clk_ext, mode: tx_mode_e'(cfg_mode), div8: cfg_div8,
                       irda_en: cfg_irda_en, invert: cfg_invert};
    end

    assign in_ready = !busy && mode_is_async(cfg_q.mode);
    assign start    = in_valid && in_ready;

    irda_tx_clksrc #(.SYNC_STAGES(SYNC_STAGES)) u_clksrc (
        .clk      (clk),
        .rst      (rst),
        .use_ext  (cfg_q.clk_ext),
        .tmr_tick (tmr_tick),
        .ext_clk  (ext_clk),
        .tick     (tick)
    );

    irda_tx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start     (start),
        .frame_in  (build_frame(cfg_q.mode, in_data)),
        .last_idx  (frame_last(cfg_q.mode)),
        .period_m1 (period_last(cfg_q.div8)),
        .busy      (busy),
        .cur_bit   (cur_bit),
        .phase     (phase)
    );

    irda_tx_encoder #(.PULSE_LEN(PULSE_LEN)) u_enc (
        .busy    (busy),
        .cur_bit (cur_bit),
        .phase   (phase),
        .irda_en (cfg_q.irda_en),
        .invert  (cfg_q.invert),
        .tx      (tx_out)
    );

endmodule

// File: rtl/irda_async_tx_chk.sv
module irda_async_tx_chk
    import irda_tx_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    in_valid,
    input logic    in_ready,
    input logic    busy,
    input logic    tx_out,
    input tx_cfg_t cfg
);
    a_r8_ready_low_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

    a_r8_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy);

    a_r2_clocked_mode_blocks: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_CLK_MASTER || cfg.mode == MODE_CLK_SLAVE) |-> !in_ready);

    a_r9_cfg_frozen_in_frame: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg));

    a_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tx_out == (cfg.irda_en ? !cfg.invert : 1'b1)));

endmodule

bind irda_async_tx irda_async_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .tx_out   (tx_out),
    .cfg      (cfg_q)
);

// File: tb/irda_async_tx_tb_top.sv
module irda_async_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tmr_tick = 1'b0;
    logic       ext_clk = 1'b0;
    logic       ext_run = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_clk_ext = 1'b0;
    logic [1:0] cfg_mode = 2'b11;
    logic       cfg_div8 = 1'b0;
    logic       cfg_irda_en = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       busy;
    logic       tx_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [2:0] ext_cnt = 3'd0;

    always #2 clk = ~clk;

    irda_async_tx dut_i (
        .clk(clk), .rst(rst), .tmr_tick(tmr_tick), .ext_clk(ext_clk),
        .cfg_we(cfg_we), .cfg_clk_ext(cfg_clk_ext), .cfg_mode(cfg_mode),
        .cfg_div8(cfg_div8), .cfg_irda_en(cfg_irda_en), .cfg_invert(cfg_invert),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .busy(busy), .tx_out(tx_out)
    );

    always @(negedge clk) begin
        if (ext_run) begin
            ext_cnt <= ext_cnt + 3'd1;
            ext_clk <= ext_cnt[1];
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual run still going, expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic ext, input logic [1:0] m, input logic d8,
                             input logic ir, input logic inv);
        @(negedge clk);
        cfg_clk_ext = ext; cfg_mode = m; cfg_div8 = d8; cfg_irda_en = ir; cfg_invert = inv;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic one_tick();
        tmr_tick = 1'b1;
        @(negedge clk);
        tmr_tick = 1'b0;
    endtask

    function automatic logic frame_bit(input logic [1:0] m, input logic [7:0] d, input int idx);
        int nb;
        nb = (m == 2'b10) ? 7 : 8;
        if (idx == 0) return 1'b0;
        if (idx <= nb) return d[idx-1];
        return 1'b1;
    endfunction

    function automatic logic exp_line(input logic b, input int ph, input logic ir, input logic inv);
        if (!ir) return b;
        if (!b && ph < 3) return inv;
        return !inv;
    endfunction

    // Sends one byte on the internal tick and checks every tick slot (R3, R4, R6, R7, R8).
    task automatic run_frame(input logic [1:0] m, input logic d8, input logic ir,
                             input logic inv, input logic [7:0] d);
        int nbits;
        int per;
        nbits = (m == 2'b10) ? 9 : 10;
        per   = d8 ? 8 : 16;
        write_cfg(1'b0, m, d8, ir, inv);
        check("R8 ready before accept", in_ready, 1'b1);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 busy after accept", busy, 1'b1);
        for (int b = 0; b < nbits; b++) begin
            for (int p = 0; p < per; p++) begin
                check("R3/R6 line", tx_out, exp_line(frame_bit(m, d, b), p, ir, inv));
                check("R4 busy inside frame", busy, 1'b1);
                one_tick();
            end
        end
        check("R4 busy drops after stop", busy, 1'b0);
        check("R7 idle after frame", tx_out, ir ? !inv : 1'b1);
    endtask

    // {mode[12:11], div8[10], irda[9], invert[8], data[7:0]}
    localparam logic [12:0] VEC [8] = '{
        {2'b11, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'b11, 1'b1, 1'b0, 1'b1, 8'h3C},
        {2'b10, 1'b0, 1'b0, 1'b0, 8'hC5},
        {2'b11, 1'b0, 1'b1, 1'b0, 8'h96},
        {2'b11, 1'b1, 1'b1, 1'b1, 8'h01},
        {2'b10, 1'b1, 1'b1, 1'b0, 8'hFE},
        {2'b10, 1'b0, 1'b1, 1'b1, 8'h80},
        {2'b11, 1'b1, 1'b1, 1'b0, 8'h00}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 tx_out reset", tx_out, 1'b1);
        check("R1 busy reset", busy, 1'b0);
        check("R1 in_ready reset", in_ready, 1'b1);

        // R1 default config: one frame with no write, 16 ticks/bit, NRZ
        in_valid = 1'b1; in_data = 8'h5A;
        @(negedge clk);
        in_valid = 1'b0;
        for (int b = 0; b < 10; b++)
            for (int p = 0; p < 16; p++) begin
                check("R1 default frame", tx_out, frame_bit(2'b11, 8'h5A, b));
                one_tick();
            end
        check("R1 default frame end", busy, 1'b0);

        for (int v = 0; v < 8; v++)
            run_frame(VEC[v][12:11], VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0]);

        // R2: clocked modes never start a frame, even with infrared on
        for (int k = 0; k < 2; k++) begin
            write_cfg(1'b0, k[1:0], 1'b1, 1'b1, 1'b0);
            check("R2 ready low in clocked mode", in_ready, 1'b0);
            in_valid = 1'b1; in_data = 8'h00;
            @(negedge clk);
            in_valid = 1'b0;
            for (int t = 0; t < 4; t++) one_tick();
            check("R2 no busy in clocked mode", busy, 1'b0);
            check("R2 idle line in clocked mode", tx_out, 1'b1);
        end

        // R9: write refused during a frame
        write_cfg(1'b0, 2'b11, 1'b1, 1'b1, 1'b0);
        in_valid = 1'b1; in_data = 8'hFF;
        @(negedge clk);
        in_valid = 1'b0;
        one_tick();
        cfg_clk_ext = 1'b0; cfg_mode = 2'b11; cfg_div8 = 1'b1; cfg_irda_en = 1'b1;
        cfg_invert = 1'b1; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int t = 1; t < 80; t++) begin
            if (t >= 8) check("R9 polarity kept in frame", tx_out, 1'b1);
            one_tick();
        end
        check("R9 frame ended", busy, 1'b0);
        check("R9 old polarity after frame", tx_out, 1'b1);
        write_cfg(1'b0, 2'b11, 1'b1, 1'b1, 1'b1);
        check("R9 idle write applied", tx_out, 1'b0);
        check("R7 inverted idle low", tx_out, 1'b0);
        write_cfg(1'b0, 2'b11, 1'b1, 1'b0, 1'b1);
        check("R7 NRZ ignores polarity", tx_out, 1'b1);

        // R5: external clock, with the internal tick held high to catch a wrong source
        write_cfg(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        ext_run = 1'b1;
        tmr_tick = 1'b1;
        in_valid = 1'b1; in_data = 8'hFF;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 start bit on ext clock", tx_out, 1'b0);
        repeat (629) @(negedge clk);
        check("R5 still busy at 630 cycles", busy, 1'b1);
        repeat (20) @(negedge clk);
        check("R5 done by 650 cycles", busy, 1'b0);
        tmr_tick = 1'b0;
        ext_run = 1'b0;

        // R1: reset returns the idle state
        write_cfg(1'b0, 2'b11, 1'b1, 1'b1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle high after reset", tx_out, 1'b1);
        check("R1 ready after reset", in_ready, 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule